// File: doc/BRIEF.md
# Streaming Radix-2 Delay-Feedback FFT

This block computes an N-point discrete Fourier transform on a stream of complex samples. It takes one sample per valid cycle and returns one result per valid cycle, with no gap between frames. It has log2(N) stages in a chain. Each stage holds one butterfly and one feedback delay line of N/2, N/4, …, 1 words, so the delay storage totals N−1 complex words. Every stage except the last also has a complex twiddle rotator, so there is one rotator fewer than there are stages.

Each stage alternates between two phases. In the loading phase it pushes the arriving sample into its delay line and forwards the older value that leaves the line. In the combining phase it outputs the sum of the delayed and arriving samples and writes their difference back into the line. No scaling is applied. The word grows by one bit per stage, and one guard bit is added at the entry, so a full-scale input cannot overflow. Results leave the block in bit-reversed index order, and a marker flags the first result of each frame. A low `inValid` freezes the whole pipeline for that cycle.

Top module: `fftSdfPipe`

## Requirements
- R1: After a synchronous reset (`rstN` low at a clock edge), `outValid` and `outFirst` are 0. `outValid` stays 0 until N+log2(N)−1 valid input samples have been accepted since reset.
- R2: Output position m (0..N−1) within a frame carries X[k], where k is m with its log2(N) index bits reversed and X[k] = Σn x[n]·e^(−j2πkn/N). Each result is within a small fixed-point tolerance of this value, in the input LSB unit.
- R3: Results are IN_W+log2(N)+1 bits wide, with the same number of fraction bits as the input. Full-scale inputs (all +max, or alternating +max/−min) produce exact in-range sums with no wrap.
- R4: `outFirst` is 1 together with `outValid` exactly at output position 0 of each frame. Two consecutive `outFirst` pulses are N valid outputs apart.
- R5: Once primed, every cycle that accepted a valid input is followed one clock later by `outValid` = 1. Back-to-back frames stream with no idle cycles.
- R6: A cycle with `inValid` low produces `outValid` = 0 on the next cycle, keeps `outRe`/`outIm` unchanged, and leaves later results unaffected.
- R7: An impulse of amplitude A at sample 0 gives exactly A (imaginary part 0) at every output position, with no rounding error.
- R8: A reset asserted in the middle of a frame discards the partial frame. The next frame after reset is transformed correctly, with the latency of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset of the control state |
| inValid | input | 1 | Sample present this cycle; low stalls the pipeline |
| inRe | input | IN_W | Input real part, signed, IN_W−1 fraction bits |
| inIm | input | IN_W | Input imaginary part, signed |
| outValid | output | 1 | Result present |
| outFirst | output | 1 | Result is position 0 of a frame |
| outRe | output | IN_W+log2(N)+1 | Result real part, signed, IN_W−1 fraction bits |
| outIm | output | IN_W+log2(N)+1 | Result imaginary part, signed |

## Verification
A scoreboard compares each frame against a floating-point DFT in bit-reversed order. A design with a wrong twiddle sign or phase alignment would get every non-DC bin wrong, while still passing the impulse-at-zero case, which isolates the pure butterfly path. Full-scale DC and Nyquist frames stress the word growth, so a missing guard bit shows up as a wrapped sign. Gapped input and a reset in the middle of a frame test that stalls freeze every counter and delay line together, and that the frame marker and the first-result cycle realign to the new stream instead of keeping the old phase.

// File: rtl/fftSdfPkg.sv
package fftSdfPkg;

  typedef struct packed {
    logic advance;
  } ctrlStrobes_t;

  localparam real PI_VAL = 3.14159265358979323846;
  localparam int SERIES_TERMS = 24;

  function automatic real cosSeries(real th);
    real term;
    real acc;
    term = 1.0;
    acc  = 1.0;
    for (int i = 1; i < SERIES_TERMS; i++) begin
      term = -term * th * th / ((2.0 * i - 1.0) * (2.0 * i));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic real sinSeries(real th);
    real term;
    real acc;
    term = th;
    acc  = th;
    for (int i = 1; i < SERIES_TERMS; i++) begin
      term = -term * th * th / ((2.0 * i) * (2.0 * i + 1.0));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic int toFixed(real v, int frac);
    real scale;
    real s;
    scale = 1.0;
    for (int i = 0; i < frac; i++) scale = scale * 2.0;
    s = v * scale;
    if (s >= 0.0) return $rtoi(s + 0.5);
    return -$rtoi(0.5 - s);
  endfunction

  // Rotation angle for slot k of a stage whose delay spans `span` words: pi*k/span
  function automatic int twCos(int k, int span, int frac);
    return toFixed(cosSeries(PI_VAL * k / span), frac);
  endfunction

  function automatic int twSin(int k, int span, int frac);
    return toFixed(sinSeries(PI_VAL * k / span), frac);
  endfunction

endpackage

// File: rtl/fftSdfCtrl.sv
module fftSdfCtrl #(
  parameter int N      = 16,
  parameter int STAGES = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  output fftSdfPkg::ctrlStrobes_t     strobes,
  output logic [STAGES-1:0]           sampleCnt,
  output logic                        outValid,
  output logic                        outFirst
);
  // pushes needed before the output register holds position 0 of frame 0
  localparam int PRIME     = N + STAGES - 2;
  localparam int PRIME_W   = $clog2(PRIME + 1);
  localparam int FIRST_CNT = PRIME % N;

  logic [PRIME_W-1:0] primeCnt;
  logic               primed;

  assign primed          = (primeCnt == PRIME_W'(PRIME));
  assign strobes.advance = inValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCnt <= '0;
      primeCnt  <= '0;
      outValid  <= 1'b0;
      outFirst  <= 1'b0;
    end else begin
      outValid <= inValid && primed;
      outFirst <= inValid && primed && (sampleCnt == STAGES'(FIRST_CNT));
      if (inValid) begin
        sampleCnt <= sampleCnt + 1'b1;
        if (!primed) primeCnt <= primeCnt + PRIME_W'(1);
      end
    end
  end
endmodule

// File: rtl/fftSdfStage.sv
module fftSdfStage #(
  parameter int IN_W   = 17,
  parameter int SPAN   = 8,
  parameter int FRAC   = 15,
  parameter bit HAS_TW = 1'b1
) (
  input  logic                            clk,
  input  fftSdfPkg::ctrlStrobes_t         strobes,
  input  logic [$clog2(SPAN):0]           locCnt,
  input  logic signed [IN_W-1:0]          inRe,
  input  logic signed [IN_W-1:0]          inIm,
  output logic signed [IN_W:0]            outRe,
  output logic signed [IN_W:0]            outIm
);
  localparam int DW   = IN_W + 1;
  localparam int LW   = $clog2(SPAN);
  localparam int TW_W = FRAC + 2;
  localparam int PW   = DW + TW_W + 1;

  logic                 fillPh;
  logic signed [DW-1:0] xRe, xIm;
  logic signed [DW-1:0] tailRe, tailIm;
  logic signed [DW-1:0] sumRe, sumIm, difRe, difIm;
  logic signed [DW-1:0] wrRe, wrIm;
  logic signed [DW-1:0] rotRe, rotIm;
  logic signed [DW-1:0] preRe, preIm;
  logic signed [DW-1:0] dlyRe [SPAN];
  logic signed [DW-1:0] dlyIm [SPAN];

  assign fillPh = ~locCnt[LW];
  assign xRe    = DW'(inRe);
  assign xIm    = DW'(inIm);
  assign tailRe = dlyRe[SPAN-1];
  assign tailIm = dlyIm[SPAN-1];

  // butterfly: delayed sample is the earlier half of the pair
  assign sumRe = tailRe + xRe;
  assign sumIm = tailIm + xIm;
  assign difRe = tailRe - xRe;
  assign difIm = tailIm - xIm;
  assign wrRe  = fillPh ? xRe : difRe;
  assign wrIm  = fillPh ? xIm : difIm;

  always_ff @(posedge clk) begin
    if (strobes.advance) begin
      dlyRe[0] <= wrRe;
      dlyIm[0] <= wrIm;
      for (int i = 1; i < SPAN; i++) begin
        dlyRe[i] <= dlyRe[i-1];
        dlyIm[i] <= dlyIm[i-1];
      end
    end
  end

  generate
    if (HAS_TW) begin : g_rot
      logic signed [TW_W-1:0] cosTab [SPAN];
      logic signed [TW_W-1:0] sinTab [SPAN];
      logic signed [TW_W-1:0] cSel, sSel;
      logic signed [PW-1:0]   accRe, accIm;

      for (genvar k = 0; k < SPAN; k++) begin : g_rom
        localparam int C_VAL = fftSdfPkg::twCos(k, SPAN, FRAC);
        localparam int S_VAL = fftSdfPkg::twSin(k, SPAN, FRAC);
        assign cosTab[k] = TW_W'(C_VAL);
        assign sinTab[k] = TW_W'(S_VAL);
      end

      assign cSel = cosTab[locCnt[LW-1:0]];
      assign sSel = sinTab[locCnt[LW-1:0]];
      // (re + j im) * (c - j s)
      assign accRe = PW'(tailRe) * PW'(cSel) + PW'(tailIm) * PW'(sSel);
      assign accIm = PW'(tailIm) * PW'(cSel) - PW'(tailRe) * PW'(sSel);
      assign rotRe = DW'(accRe >>> FRAC);
      assign rotIm = DW'(accIm >>> FRAC);
    end else begin : g_pass
      assign rotRe = tailRe;
      assign rotIm = tailIm;
    end
  endgenerate

  assign preRe = fillPh ? rotRe : sumRe;
  assign preIm = fillPh ? rotIm : sumIm;

  always_ff @(posedge clk) begin
    if (strobes.advance) begin
      outRe <= preRe;
      outIm <= preIm;
    end
  end
endmodule

// File: rtl/fftSdfDatapath.sv
module fftSdfDatapath #(
  parameter int N      = 16,
  parameter int IN_W   = 16,
  parameter int STAGES = 4
) (
  input  logic                              clk,
  input  fftSdfPkg::ctrlStrobes_t           strobes,
  input  logic [STAGES-1:0]                 sampleCnt,
  input  logic signed [IN_W-1:0]            inRe,
  input  logic signed [IN_W-1:0]            inIm,
  output logic signed [IN_W+STAGES:0]       outRe,
  output logic signed [IN_W+STAGES:0]       outIm
);
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      localparam int SPAN = N >> (s + 1);
      localparam int LW   = $clog2(SPAN);
      localparam int IW   = IN_W + 1 + s;

      logic signed [IW-1:0] stInRe, stInIm;
      logic signed [IW:0]   stOutRe, stOutIm;
      logic [LW:0]          stCnt;

      // each stage register shifts the phase by one sample
      assign stCnt = sampleCnt[LW:0] - (LW + 1)'(s);

      if (s == 0) begin : g_head
        assign stInRe = IW'(inRe);
        assign stInIm = IW'(inIm);
      end else begin : g_link
        assign stInRe = g_stage[s-1].stOutRe;
        assign stInIm = g_stage[s-1].stOutIm;
      end

      fftSdfStage #(
        .IN_W  (IW),
        .SPAN  (SPAN),
        .FRAC  (IN_W - 1),
        .HAS_TW(s < STAGES - 1)
      ) u_stage (
        .clk    (clk),
        .strobes(strobes),
        .locCnt (stCnt),
        .inRe   (stInRe),
        .inIm   (stInIm),
        .outRe  (stOutRe),
        .outIm  (stOutIm)
      );
    end
  endgenerate

  assign outRe = g_stage[STAGES-1].stOutRe;
  assign outIm = g_stage[STAGES-1].stOutIm;
endmodule

// File: rtl/fftSdfPipe.sv
module fftSdfPipe #(
  parameter int N    = 16,
  parameter int IN_W = 16
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  inValid,
  input  logic signed [IN_W-1:0]                inRe,
  input  logic signed [IN_W-1:0]                inIm,
  output logic                                  outValid,
  output logic                                  outFirst,
  output logic signed [IN_W+$clog2(N):0]        outRe,
  output logic signed [IN_W+$clog2(N):0]        outIm
);
  localparam int STAGES = $clog2(N);
  localparam int OUT_W  = IN_W + STAGES + 1;

  fftSdfPkg::ctrlStrobes_t strobes;
  logic [STAGES-1:0]       sampleCnt;

  fftSdfCtrl #(.N(N), .STAGES(STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .sampleCnt(sampleCnt),
    .outValid (outValid),
    .outFirst (outFirst)
  );

  fftSdfDatapath #(.N(N), .IN_W(IN_W), .STAGES(STAGES)) u_dp (
    .clk      (clk),
    .strobes  (strobes),
    .sampleCnt(sampleCnt),
    .inRe     (inRe),
    .inIm     (inIm),
    .outRe    (outRe),
    .outIm    (outIm)
  );
endmodule

// File: rtl/fftSdfPipeChk.sv
module fftSdfPipeChk #(
  parameter int N     = 16,
  parameter int OUT_W = 21
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    outValid,
  input logic                    outFirst,
  input logic signed [OUT_W-1:0] outRe,
  input logic signed [OUT_W-1:0] outIm
);
  localparam int GAP_W = $clog2(N) + 2;

  logic             seenFirst;
  logic [GAP_W-1:0] validGap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenFirst <= 1'b0;
      validGap  <= '0;
    end else if (outValid) begin
      if (outFirst) begin
        seenFirst <= 1'b1;
        validGap  <= GAP_W'(1);
      end else if (validGap != {GAP_W{1'b1}}) begin
        validGap <= validGap + GAP_W'(1);
      end
    end
  end

  AST_FIRST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outFirst |-> outValid); // R4

  AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFirst && seenFirst) |-> (validGap == GAP_W'(N))); // R4

  AST_VALID_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid)); // R5

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outRe) && $stable(outIm))); // R6
endmodule

bind fftSdfPipe fftSdfPipeChk #(.N(N), .OUT_W(OUT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outValid(outValid),
  .outFirst(outFirst),
  .outRe   (outRe),
  .outIm   (outIm)
);

// File: tb/fftSdfPipe_tb.sv
module fftSdfPipe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N      = 16;
  localparam int IN_W   = 16;
  localparam int STAGES = 4;
  localparam int OUT_W  = IN_W + STAGES + 1;
  localparam int LAT    = N + STAGES - 1;
  localparam int TOL    = 96;
  localparam real PI    = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [IN_W-1:0] inRe = '0, inIm = '0;
  logic outValid, outFirst;
  logic signed [OUT_W-1:0] outRe, outIm;

  fftSdfPipe #(.N(N), .IN_W(IN_W)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inRe(inRe), .inIm(inIm),
    .outValid(outValid), .outFirst(outFirst), .outRe(outRe), .outIm(outIm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  real   expReQ[$];
  real   expImQ[$];
  int    tolQ[$];
  bit    firstQ[$];
  string tagQ[$];
  int pushCnt = 0;
  bit prevIn = 1'b0;
  bit haveLast = 1'b0;
  bit done = 1'b0;
  logic signed [OUT_W-1:0] lastRe = '0, lastIm = '0;
  int frRe[N];
  int frIm[N];
  int unsigned seed = 32'h1234_5678;

  task automatic note(bit ok, string req, string what, real act, real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0f expected=%0f", req, what, act, exp);
    end
  endtask

  function automatic int bitRev(int k);
    int r = 0;
    for (int b = 0; b < STAGES; b++) if (k[b]) r |= 1 << (STAGES - 1 - b);
    return r;
  endfunction

  function automatic int nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % 32000) - 16000;
  endfunction

  // push counter and previous-cycle input, sampled at the same edge the design uses
  always @(posedge clk) begin
    if (!rstN) begin
      pushCnt <= 0;
      prevIn  <= 1'b0;
    end else begin
      prevIn <= inValid;
      if (inValid && pushCnt < 1000000) pushCnt <= pushCnt + 1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rstN) begin
      haveLast = 1'b0;
    end else if (!done) begin
      if (!prevIn) begin
        note(!outValid, "R6", "outValid after idle cycle", outValid, 0);
        if (haveLast)
          note(outRe == lastRe && outIm == lastIm, "R6", "data held on idle", outRe, lastRe);
      end else if (pushCnt >= LAT) begin
        note(outValid, "R5", "outValid after primed push", outValid, 1);
      end else begin
        note(!outValid, "R1", "no result before latency", outValid, 0);
      end
      if (outValid && expReQ.size() > 0) begin
        real er, ei;
        int  tl;
        bit  ef;
        string tg;
        er = expReQ.pop_front();
        ei = expImQ.pop_front();
        tl = tolQ.pop_front();
        ef = firstQ.pop_front();
        tg = tagQ.pop_front();
        note(((outRe - er) <= tl) && ((er - outRe) <= tl), tg, "real part", outRe, er);
        note(((outIm - ei) <= tl) && ((ei - outIm) <= tl), tg, "imag part", outIm, ei);
        note(outFirst == ef, "R4", "frame marker", outFirst, ef);
      end
      lastRe   = outRe;
      lastIm   = outIm;
      haveLast = 1'b1;
    end
  end

  // kind: 0 impulse@0, 1 random, 2 full-scale DC, 3 full-scale alternating, 4 impulse@3, 5 zeros
  task automatic runFrame(int kind, int gap, bit expect_, string tag, int tol);
    for (int n = 0; n < N; n++) begin
      case (kind)
        0: begin frRe[n] = (n == 0) ? 12000 : 0; frIm[n] = 0; end
        1: begin frRe[n] = nextRand(); frIm[n] = nextRand(); end
        2: begin frRe[n] = 32767; frIm[n] = -32768; end
        3: begin frRe[n] = (n % 2 == 0) ? 32767 : -32768; frIm[n] = 0; end
        4: begin frRe[n] = (n == 3) ? 9000 : 0; frIm[n] = (n == 3) ? -7000 : 0; end
        default: begin frRe[n] = 0; frIm[n] = 0; end
      endcase
    end
    if (expect_) begin
      for (int m = 0; m < N; m++) begin
        int k = bitRev(m);
        real xr = 0.0, xi = 0.0;
        for (int n = 0; n < N; n++) begin
          real th = 2.0 * PI * k * n / N;
          xr += frRe[n] * $cos(th) + frIm[n] * $sin(th);
          xi += frIm[n] * $cos(th) - frRe[n] * $sin(th);
        end
        expReQ.push_back(xr);
        expImQ.push_back(xi);
        tolQ.push_back(tol);
        firstQ.push_back(m == 0);
        tagQ.push_back(tag);
      end
    end
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      inValid = 1'b1;
      inRe = IN_W'(frRe[n]);
      inIm = IN_W'(frIm[n]);
      if (gap > 0 && (n % gap) == gap - 1) begin
        @(negedge clk);
        inValid = 1'b0;
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    inValid = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic idle(int cycles);
    @(negedge clk);
    inValid = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    doReset();
    @(negedge clk);
    note(!outValid, "R1", "outValid after reset", outValid, 0);
    note(!outFirst, "R1", "outFirst after reset", outFirst, 0);

    // segment A: continuous stream of varied frames
    runFrame(0, 0, 1'b1, "R7", 0);
    runFrame(1, 0, 1'b1, "R2", TOL);
    runFrame(4, 0, 1'b1, "R2", TOL);
    runFrame(2, 0, 1'b1, "R3", TOL);
    runFrame(3, 0, 1'b1, "R3", TOL);
    runFrame(1, 3, 1'b1, "R6", TOL);
    runFrame(1, 0, 1'b1, "R2", TOL);
    runFrame(5, 0, 1'b0, "", 0);
    runFrame(5, 0, 1'b0, "", 0);
    idle(4);
    note(expReQ.size() == 0, "R2", "segment A results delivered", expReQ.size(), 0);

    // segment B: reset in the middle of a frame
    for (int n = 0; n < N / 2; n++) begin
      @(negedge clk);
      inValid = 1'b1;
      inRe = IN_W'(nextRand());
      inIm = IN_W'(nextRand());
    end
    doReset();
    runFrame(1, 0, 1'b1, "R8", TOL);
    runFrame(0, 0, 1'b1, "R8", 0);
    runFrame(5, 0, 1'b0, "", 0);
    runFrame(5, 0, 1'b0, "", 0);
    idle(4);
    note(expReQ.size() == 0, "R8", "segment B results delivered", expReQ.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule